// File: doc/BRIEF.md
# Program Exception PSW Commit Unit

This block performs the state change that follows a detected program exception. A one-cycle `start` pulse captures the current PSW (mask and address), the interruption code, the instruction length, the pending program-event-recording (PER) status with its event address, the breaking-event address, and the new-PSW pair from the vector port. In the next cycle the block raises `done` for exactly one cycle. In that same cycle it writes the save record and loads the new PSW.

The interruption code decides where the saved old-PSW address points. For a completing code, the saved address points past the faulting instruction. For any other code, it points at the instruction itself. A PER-only exception advances the address unless its event-nullification flag is set. Any pending PER event is folded into the same delivery: the PER bit is set in the stored code, the PER fields are written, and a clear pulse is sent back to the PER logic. Every record field is presented big-endian. A length that the code does not permit is flagged on an error output.

Top module: `pgm_exc_commit`

## Requirements
- R1: After reset, `done`, `rec_we`, `psw_ld`, `rec_per_we`, `per_clr` and `len_err` are all 0, and every record and PSW data output is 0.
- R2: A `start` sampled while `done` is low is accepted. `done`, `rec_we` and `psw_ld` are then high together for exactly the one following cycle.
- R3: A `start` sampled while `done` is high is ignored. No commit follows it, and the record presented at that `done` still carries the values captured by the accepted request.
- R4: The completing codes are 0x0001 to 0x000F, 0x0012, 0x0013, 0x0015, 0x001D and 0x0040. For these, the saved old address is the current address plus the instruction length, modulo 2^ADDR_W.
- R5: Every code that is neither completing nor exactly 0x0080 saves the current address unchanged. This includes any code that already carries bit 0x0080 together with other bits.
- R6: For code 0x0080 (PER only), the address advances by the length when bit 7 of `per_code` is 0, and stays unchanged when that bit is 1.
- R7: PER status is pending when `per_code` is nonzero. When it is pending, the stored code is the input code ORed with 0x0080, `rec_per_we` and `per_clr` pulse with `done`, and the PER code and address are recorded. When it is not pending, the code is stored as given and neither pulse occurs.
- R8: `len_err` pulses with `done` unless the length is 2, 4 or 6, or the length is 0 and the code is 0x0006.
- R9: Every record field is big-endian. Byte 0 (bits 7:0) of each output field holds the most significant byte of the value, and the 16-bit length field holds the zero-extended length.
- R10: When `psw_ld` is high, `psw_mask` and `psw_addr` equal the vector-port mask and address captured with the accepted `start`.
- R11: The record holds, as the old PSW mask, the captured current mask unchanged, and it holds the captured breaking-event address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse that captures all request inputs |
| cur_mask | input | MASK_W | Current PSW mask |
| cur_addr | input | ADDR_W | Current PSW address (address of the faulting instruction) |
| exc_code | input | 16 | Program-interruption code |
| exc_ilen | input | LEN_W | Instruction length in bytes |
| per_code | input | 16 | Pending PER code/identifier halfword; nonzero means pending |
| per_addr | input | ADDR_W | PER event address |
| bea | input | ADDR_W | Breaking-event address |
| vec_mask | input | MASK_W | New-PSW mask from the vector port |
| vec_addr | input | ADDR_W | New-PSW address from the vector port |
| done | output | 1 | One-cycle completion pulse |
| len_err | output | 1 | Illegal length/code combination, valid with done |
| rec_we | output | 1 | Save-record write strobe |
| rec_ilen | output | 16 | Stored length, big-endian |
| rec_code | output | 16 | Stored interruption code, big-endian |
| rec_old_mask | output | MASK_W | Old PSW mask, big-endian |
| rec_old_addr | output | ADDR_W | Old PSW address, big-endian |
| rec_bea | output | ADDR_W | Breaking-event address, big-endian |
| rec_per_we | output | 1 | PER fields write strobe |
| rec_per_code | output | 16 | PER code halfword, big-endian |
| rec_per_addr | output | ADDR_W | PER event address, big-endian |
| per_clr | output | 1 | Clears the pending PER status |
| psw_ld | output | 1 | Loads the new PSW into the current PSW |
| psw_mask | output | MASK_W | New PSW mask to load |
| psw_addr | output | ADDR_W | New PSW address to load |

## Verification
The assertions check the handshake timing on every cycle: acceptance only while idle, a `done` of one cycle, a commit that never follows a request made during `done`, and error and PER-clear pulses that appear only with `done`. They also check, on every cycle, that a nullified PER-only event never advances the address and that a PER record write always carries the PER bit in the stored code. The saved address values for each code class, the wrap at the top of the address space, the big-endian byte placement and the pass-through of the vector port can only be shown by the bench scenarios, which compare the record against values the bench computes from the requirements.

// File: rtl/pexc_pkg.sv
package pexc_pkg;
  localparam int CODE_W = 16;
  localparam logic [CODE_W-1:0] PER_ONLY_CODE = 16'h0080;
  localparam logic [CODE_W-1:0] SPEC_CODE     = 16'h0006;
  localparam int PER_NULL_BIT = 7;

  // Codes whose delivery completes the instruction (address moves past it).
  function automatic logic is_completing(input logic [CODE_W-1:0] c);
    logic r;
    r = 1'b0;
    if (c >= 16'h0001 && c <= 16'h000F) r = 1'b1;
    case (c)
      16'h0012, 16'h0013, 16'h0015, 16'h001D, 16'h0040: r = 1'b1;
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pexc_bswap.sv
module pexc_bswap #(
  parameter int W = 64
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NB = W / 8;
  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign dout[8*b +: 8] = din[W-8-8*b +: 8];
  end
endmodule

// File: rtl/pexc_classify.sv
module pexc_classify
  import pexc_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic [CODE_W-1:0] code,
  input  logic [LEN_W-1:0]  ilen,
  input  logic [CODE_W-1:0] per_code,
  output logic              adv_en,
  output logic              per_pend,
  output logic              per_null_hit,
  output logic              len_bad
);
  logic per_only;
  logic len_legal;

  assign per_only     = (code == PER_ONLY_CODE);
  assign per_pend     = (per_code != '0);
  assign per_null_hit = per_only & per_code[PER_NULL_BIT];

  always_comb begin
    adv_en = is_completing(code);
    if (per_only && !per_code[PER_NULL_BIT]) adv_en = 1'b1;
  end

  always_comb begin
    len_legal = 1'b0;
    if (ilen == LEN_W'(2) || ilen == LEN_W'(4) || ilen == LEN_W'(6)) len_legal = 1'b1;
    if (ilen == '0 && code == SPEC_CODE) len_legal = 1'b1;
  end
  assign len_bad = ~len_legal;
endmodule

// File: rtl/pgm_exc_commit.sv
module pgm_exc_commit
  import pexc_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int MASK_W = 64,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MASK_W-1:0] cur_mask,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [15:0]       exc_code,
  input  logic [LEN_W-1:0]  exc_ilen,
  input  logic [15:0]       per_code,
  input  logic [ADDR_W-1:0] per_addr,
  input  logic [ADDR_W-1:0] bea,
  input  logic [MASK_W-1:0] vec_mask,
  input  logic [ADDR_W-1:0] vec_addr,
  output logic              done,
  output logic              len_err,
  output logic              rec_we,
  output logic [15:0]       rec_ilen,
  output logic [15:0]       rec_code,
  output logic [MASK_W-1:0] rec_old_mask,
  output logic [ADDR_W-1:0] rec_old_addr,
  output logic [ADDR_W-1:0] rec_bea,
  output logic              rec_per_we,
  output logic [15:0]       rec_per_code,
  output logic [ADDR_W-1:0] rec_per_addr,
  output logic              per_clr,
  output logic              psw_ld,
  output logic [MASK_W-1:0] psw_mask,
  output logic [ADDR_W-1:0] psw_addr
);
  // Captured request
  logic              done_q;
  logic [MASK_W-1:0] c_mask, c_vmask;
  logic [ADDR_W-1:0] c_addr, c_paddr, c_bea, c_vaddr;
  logic [CODE_W-1:0] c_code, c_pcode;
  logic [LEN_W-1:0]  c_ilen;

  // Named internal events
  logic              accept;
  logic              adv_en, per_pend, per_null_hit, len_bad;
  logic [ADDR_W-1:0] old_addr;
  logic [CODE_W-1:0] stored_code;
  logic [15:0]       ilen_ext;

  assign accept = start & ~done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      c_mask  <= '0;
      c_vmask <= '0;
      c_addr  <= '0;
      c_paddr <= '0;
      c_bea   <= '0;
      c_vaddr <= '0;
      c_code  <= '0;
      c_pcode <= '0;
      c_ilen  <= '0;
    end else begin
      done_q <= accept;
      if (accept) begin
        c_mask  <= cur_mask;
        c_vmask <= vec_mask;
        c_addr  <= cur_addr;
        c_paddr <= per_addr;
        c_bea   <= bea;
        c_vaddr <= vec_addr;
        c_code  <= exc_code;
        c_pcode <= per_code;
        c_ilen  <= exc_ilen;
      end
    end
  end

  pexc_classify #(.LEN_W(LEN_W)) u_class (
    .code         (c_code),
    .ilen         (c_ilen),
    .per_code     (c_pcode),
    .adv_en       (adv_en),
    .per_pend     (per_pend),
    .per_null_hit (per_null_hit),
    .len_bad      (len_bad)
  );

  assign old_addr    = adv_en ? (c_addr + ADDR_W'(c_ilen)) : c_addr;
  assign stored_code = per_pend ? (c_code | PER_ONLY_CODE) : c_code;
  assign ilen_ext    = 16'(c_ilen);

  pexc_bswap #(.W(16))     u_sw_ilen  (.din(ilen_ext),    .dout(rec_ilen));
  pexc_bswap #(.W(16))     u_sw_code  (.din(stored_code), .dout(rec_code));
  pexc_bswap #(.W(16))     u_sw_pcode (.din(c_pcode),     .dout(rec_per_code));
  pexc_bswap #(.W(MASK_W)) u_sw_mask  (.din(c_mask),      .dout(rec_old_mask));
  pexc_bswap #(.W(ADDR_W)) u_sw_addr  (.din(old_addr),    .dout(rec_old_addr));
  pexc_bswap #(.W(ADDR_W)) u_sw_bea   (.din(c_bea),       .dout(rec_bea));
  pexc_bswap #(.W(ADDR_W)) u_sw_paddr (.din(c_paddr),     .dout(rec_per_addr));

  assign done       = done_q;
  assign rec_we     = done_q;
  assign psw_ld     = done_q;
  assign len_err    = done_q & len_bad;
  assign rec_per_we = done_q & per_pend;
  assign per_clr    = done_q & per_pend;
  assign psw_mask   = c_vmask;
  assign psw_addr   = c_vaddr;
endmodule

// File: rtl/pgm_exc_commit_chk.sv
module pgm_exc_commit_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic done,
  input logic rec_we,
  input logic psw_ld,
  input logic len_err,
  input logic per_clr,
  input logic rec_per_we,
  input logic adv_en,
  input logic per_null_hit,
  input logic code_per_bit
);
  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !done) |=> (done && rec_we && psw_ld));

  a_r2_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(psw_ld) |-> $past(start));

  a_r3_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !rec_we);

  a_r6_null_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && per_null_hit) |-> !adv_en);

  a_r7_code_bit: assert property (@(posedge clk) disable iff (!rst_n)
    rec_per_we |-> code_per_bit);

  a_r7_clr_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    per_clr |-> done);

  a_r8_err_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> done);
endmodule

bind pgm_exc_commit pgm_exc_commit_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .done         (done),
  .rec_we       (rec_we),
  .psw_ld       (psw_ld),
  .len_err      (len_err),
  .per_clr      (per_clr),
  .rec_per_we   (rec_per_we),
  .adv_en       (adv_en),
  .per_null_hit (per_null_hit),
  .code_per_bit (stored_code[7])
);

// File: tb/test_pgm_exc_commit.sv
module test_pgm_exc_commit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] cur_mask = '0, cur_addr = '0, per_addr = '0, bea = '0;
  logic [63:0] vec_mask = '0, vec_addr = '0;
  logic [15:0] exc_code = '0, per_code = '0;
  logic [3:0]  exc_ilen = '0;
  logic        done, len_err, rec_we, rec_per_we, per_clr, psw_ld;
  logic [15:0] rec_ilen, rec_code, rec_per_code;
  logic [63:0] rec_old_mask, rec_old_addr, rec_bea, rec_per_addr, psw_mask, psw_addr;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pgm_exc_commit i_pgm_exc_commit (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cur_mask(cur_mask), .cur_addr(cur_addr), .exc_code(exc_code), .exc_ilen(exc_ilen),
    .per_code(per_code), .per_addr(per_addr), .bea(bea),
    .vec_mask(vec_mask), .vec_addr(vec_addr),
    .done(done), .len_err(len_err), .rec_we(rec_we), .rec_ilen(rec_ilen), .rec_code(rec_code),
    .rec_old_mask(rec_old_mask), .rec_old_addr(rec_old_addr), .rec_bea(rec_bea),
    .rec_per_we(rec_per_we), .rec_per_code(rec_per_code), .rec_per_addr(rec_per_addr),
    .per_clr(per_clr), .psw_ld(psw_ld), .psw_mask(psw_mask), .psw_addr(psw_addr)
  );

  // Big-endian view: lowest output byte takes the value's top byte.
  function automatic logic [63:0] be64(input logic [63:0] v);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = v[63-8*i -: 8];
    return r;
  endfunction
  function automatic logic [15:0] be16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive one request; returns with outputs sampled in the done cycle.
  task automatic fire(input logic [15:0] code, input logic [3:0] ilen, input logic [63:0] addr,
                      input logic [15:0] pcode);
    @(negedge clk);
    exc_code = code; exc_ilen = ilen; cur_addr = addr; per_code = pcode;
    cur_mask = 64'h0705_0000_8000_0001 ^ {48'h0, code};
    per_addr = 64'h0000_0000_00AB_CD00 + addr;
    bea      = 64'h1122_3344_5566_7788;
    vec_mask = 64'h0400_0001_8000_0000;
    vec_addr = 64'h0000_0000_0001_F000 + {48'h0, code};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "done", done, 0);
    chk("R1", "strobes", {rec_we, psw_ld, rec_per_we, per_clr, len_err}, 0);
    chk("R1", "old_addr", rec_old_addr, 0);
    chk("R1", "psw_addr", psw_addr, 0);
  endtask

  task automatic t_completing;
    fire(16'h0001, 4'd4, 64'h0000_0000_0000_1000, 16'h0);
    chk("R2", "done/we/ld", {done, rec_we, psw_ld}, 3'b111);
    chk("R4", "op addr+4", rec_old_addr, be64(64'h1004));
    chk("R9", "ilen field", rec_ilen, 16'h0400);
    chk("R9", "code field", rec_code, 16'h0100);
    chk("R11", "old mask", rec_old_mask, be64(64'h0705_0000_8000_0001 ^ 64'h1));
    chk("R11", "bea", rec_bea, be64(64'h1122_3344_5566_7788));
    chk("R10", "new mask", psw_mask, 64'h0400_0001_8000_0000);
    chk("R10", "new addr", psw_addr, 64'h0001_F001);
    chk("R7", "no per", {rec_per_we, per_clr}, 0);
    chk("R8", "no err", len_err, 0);
    @(negedge clk);
    chk("R2", "done one cycle", {done, rec_we, psw_ld}, 0);
    fire(16'h0040, 4'd6, 64'h0000_0000_0000_2000, 16'h0);
    chk("R4", "monitor addr+6", rec_old_addr, be64(64'h2006));
    fire(16'h0004, 4'd2, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0);
    chk("R4", "wrap", rec_old_addr, be64(64'h1));
    fire(16'h001D, 4'd4, 64'h3000, 16'h0);
    chk("R4", "hfp sqrt addr+4", rec_old_addr, be64(64'h3004));
  endtask

  task automatic t_nullify;
    fire(16'h0011, 4'd4, 64'h4000, 16'h0);
    chk("R5", "0x11 unchanged", rec_old_addr, be64(64'h4000));
    fire(16'h0010, 4'd6, 64'h4100, 16'h0);
    chk("R5", "0x10 unchanged", rec_old_addr, be64(64'h4100));
    fire(16'h0084, 4'd4, 64'h4200, 16'h0);
    chk("R5", "0x84 unchanged", rec_old_addr, be64(64'h4200));
  endtask

  task automatic t_per_only;
    fire(16'h0080, 4'd4, 64'h5000, 16'h4000);
    chk("R6", "flag clear advances", rec_old_addr, be64(64'h5004));
    chk("R7", "code", rec_code, be16(16'h0080));
    fire(16'h0080, 4'd4, 64'h5100, 16'h4080);
    chk("R6", "flag set holds", rec_old_addr, be64(64'h5100));
  endtask

  task automatic t_per_fold;
    fire(16'h0004, 4'd2, 64'h6000, 16'h2001);
    chk("R7", "code or per", rec_code, be16(16'h0084));
    chk("R7", "per we/clr", {rec_per_we, per_clr, done}, 3'b111);
    chk("R7", "per code", rec_per_code, be16(16'h2001));
    chk("R7", "per addr", rec_per_addr, be64(64'h00AB_CD00 + 64'h6000));
    chk("R4", "addr+2", rec_old_addr, be64(64'h6002));
  endtask

  task automatic t_len;
    fire(16'h0006, 4'd0, 64'h7000, 16'h0);
    chk("R8", "spec len0 legal", len_err, 0);
    chk("R4", "len0 addr", rec_old_addr, be64(64'h7000));
    fire(16'h0001, 4'd0, 64'h7000, 16'h0);
    chk("R8", "len0 illegal", len_err, 1);
    fire(16'h0001, 4'd3, 64'h7000, 16'h0);
    chk("R8", "len3 illegal", len_err, 1);
    fire(16'h0011, 4'd6, 64'h7000, 16'h0);
    chk("R8", "len6 legal", len_err, 0);
  endtask

  task automatic t_busy;
    @(negedge clk);
    exc_code = 16'h0002; exc_ilen = 4'd4; cur_addr = 64'h8000; per_code = 16'h0;
    start = 1'b1;
    @(negedge clk);
    chk("R3", "first done", done, 1);
    exc_code = 16'h0003; cur_addr = 64'h9000;   // keep start high: request during done
    @(negedge clk);
    start = 1'b0;
    chk("R3", "no second commit", {done, rec_we, psw_ld}, 0);
    chk("R3", "record kept", rec_old_addr, be64(64'h8004));
    chk("R3", "code kept", rec_code, be16(16'h0002));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_completing();
    t_nullify();
    t_per_only();
    t_per_fold();
    t_len();
    t_busy();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule